// File: doc/BRIEF.md
# DMA Read Prefetch FIFO

This block streams a contiguous memory region into a local byte FIFO so that a consumer can take bytes at its own pace. A fill is armed with a start address and a byte count. The engine then cuts the region into read requests and sends them out on a request channel. Each request is tagged with one of a small pool of slots. Responses carry the tag and the whole payload of that request in a single beat, and they may return in any order. The payloads enter the FIFO strictly in the order the requests were issued. The engine only issues a request when the FIFO has room for every byte already in flight plus the new one, so a response is never refused.

The request channel uses valid/ready. `req_valid_o` stays high until `req_ready_i` accepts the request. The address and length stay fixed while it waits. Valid may drop without a handshake only when stop or drain is asserted. The response channel is never back-pressured, and the engine takes one response per cycle. The consumer side is a pull interface. With `pull_valid_i` high, the consumer asks for `pull_len_i` bytes. `pull_ok_o` answers in the same cycle. The bytes are removed at the clock edge only when `pull_ok_o` is high.

A stop command ends the current fill and cancels every read in flight. Canceled reads still complete and give back their slots, but their data is dropped. A drain input holds off new requests so that the engine can settle. Two pulses report progress: one when the whole region has been requested, and one when the last outstanding read retires.

Top module: `dma_prefetch_fifo`

## Requirements
- R1: Each issued request has its address equal to the next fill address. Its length is the smaller of MAX_REQ (16) and the bytes left up to the end of the region. The next fill address then advances by that length.
- R2: At most SLOTS (3) requests are outstanding at any time. `req_valid_o` stays low while all slots are occupied, and a slot becomes free only when its request retires.
- R3: A request is offered only when the FIFO level, plus the bytes of all outstanding requests, plus the new length is no more than FIFO_BYTES (64).
- R4: Retirement takes at most one request per cycle, from the oldest outstanding slot only. A completed request that is behind an uncompleted one waits. FIFO data appears in issue order.
- R5: A `fill_stop_i` pulse ends the region at once, so no further request is offered. All outstanding reads are marked canceled. When they return, they free their slots and write nothing into the FIFO.
- R6: A pull of N bytes succeeds only when 1 <= N <= PULL_BYTES (4) and the FIFO holds at least N bytes. A successful pull removes N bytes. A failed pull removes nothing. Byte k of `pull_data_o` (bits 8k+7..8k) is the k-th oldest byte. Within a response, byte k of the payload holds address addr+k.
- R7: A `fill_start_i` pulse is honored only when the previous region has been fully requested (`block_issued_o` high). Otherwise it is ignored, and the current region continues unchanged.
- R8: `eob_o` pulses for exactly one cycle when the fill address newly reaches the region end. A zero-length start produces no pulse.
- R9: `idle_o` pulses for one cycle when the set of outstanding requests goes from non-empty to empty.
- R10: While `drain_i` is high, no request is offered. `drained_o` is high exactly when no request is outstanding.
- R11: After reset, no request is offered, `drained_o` and `block_issued_o` are high, and any pull fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_start_i | input | 1 | Pulse: arm a new region |
| fill_addr_i | input | ADDR_W | Region start address |
| fill_len_i | input | LEN_W | Region length in bytes |
| fill_stop_i | input | 1 | Pulse: end region, cancel in-flight reads |
| drain_i | input | 1 | Level: hold off new requests |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | RLW | Request length in bytes |
| req_tag_o | output | TW | Slot tag of the request |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_tag_i | input | TW | Slot tag of the response |
| rsp_data_i | input | MAX_REQ*8 | Response payload, byte k at bits 8k+7..8k |
| pull_valid_i | input | 1 | Consumer pull request |
| pull_len_i | input | PLW | Bytes wanted |
| pull_ok_o | output | 1 | Pull granted; bytes leave at this edge |
| pull_data_o | output | PULL_BYTES*8 | Oldest FIFO bytes, oldest in low byte |
| block_issued_o | output | 1 | Whole region has been requested |
| eob_o | output | 1 | One-cycle pulse: region fully requested |
| idle_o | output | 1 | One-cycle pulse: last outstanding read retired |
| drained_o | output | 1 | No request outstanding |

## Verification
Each kind of internal fault shows up at a different port. A wrong byte-ordering or retirement pointer shows as wrong or shuffled bytes on `pull_data_o` at the very next granted pull. A leak in the in-flight byte account shows as `req_valid_o` held low, or raised too early, within a cycle of the responses that should change it. Slot leaks show up when requests stop for good, or when more than three are outstanding. A stale cancel flag shows as a pull that succeeds after a stop, even though no uncanceled data remains. Start, drain and zero-length cases are checked through the address sequence and through the pulse counts.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  localparam int unsigned DPF_ADDR_W     = 32;
  localparam int unsigned DPF_LEN_W      = 16;
  localparam int unsigned DPF_FIFO_BYTES = 64;
  localparam int unsigned DPF_MAX_REQ    = 16;
  localparam int unsigned DPF_SLOTS      = 3;
  localparam int unsigned DPF_PULL_BYTES = 4;

  function automatic int unsigned dpf_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dpf_byte_fifo.sv
module dpf_byte_fifo
  import dpf_pkg::*;
#(
  parameter int unsigned DEPTH    = DPF_FIFO_BYTES,
  parameter int unsigned WR_BYTES = DPF_MAX_REQ,
  parameter int unsigned RD_BYTES = DPF_PULL_BYTES,
  localparam int unsigned IW  = dpf_bits(DEPTH),
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned WLW = $clog2(WR_BYTES + 1),
  localparam int unsigned RLW = $clog2(RD_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WLW-1:0]        wr_len,
  input  logic [WR_BYTES*8-1:0] wr_data,
  input  logic                  rd_en,
  input  logic [RLW-1:0]        rd_len,
  output logic [RD_BYTES*8-1:0] rd_data,
  output logic [CW-1:0]         level
);
  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] level_q;

  assign level = level_q;

  // storage: no reset, bytes are only read once counted in
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < WR_BYTES; i++) begin
        if (i < 32'(wr_len)) mem[IW'(wptr_q + IW'(i))] <= wr_data[i*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < RD_BYTES; i++) rd_data[i*8 +: 8] = mem[IW'(rptr_q + IW'(i))];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (wr_en) wptr_q <= IW'(wptr_q + IW'(wr_len));
      if (rd_en) rptr_q <= IW'(rptr_q + IW'(rd_len));
      level_q <= CW'(level_q + (wr_en ? CW'(wr_len) : CW'(0)) - (rd_en ? CW'(rd_len) : CW'(0)));
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(level_q) + 32'(wr_len) <= DEPTH));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(rd_len) <= 32'(level_q)));
endmodule

// File: rtl/dpf_slot_pool.sv
module dpf_slot_pool
  import dpf_pkg::*;
#(
  parameter int unsigned SLOTS   = DPF_SLOTS,
  parameter int unsigned MAX_REQ = DPF_MAX_REQ,
  localparam int unsigned TW   = dpf_bits(SLOTS),
  localparam int unsigned RLW  = $clog2(MAX_REQ + 1),
  localparam int unsigned NW   = $clog2(SLOTS + 1),
  localparam int unsigned PBW  = $clog2(SLOTS * MAX_REQ + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [RLW-1:0]       alloc_len,
  output logic [TW-1:0]        alloc_tag,
  output logic                 full_o,
  output logic                 empty_o,
  input  logic                 cancel_all,
  input  logic                 rsp_valid,
  input  logic [TW-1:0]        rsp_tag,
  input  logic [MAX_REQ*8-1:0] rsp_data,
  output logic                 retire_o,
  output logic                 retire_keep_o,
  output logic [RLW-1:0]       retire_len,
  output logic [MAX_REQ*8-1:0] retire_data,
  output logic [PBW-1:0]       pend_bytes
);
  logic [SLOTS-1:0]     busy_q, done_q, canc_q;
  logic [RLW-1:0]       len_q  [SLOTS];
  logic [MAX_REQ*8-1:0] data_q [SLOTS];
  logic [TW-1:0]        head_q, tail_q;
  logic [NW-1:0]        cnt_q;
  logic [PBW-1:0]       pend_q;

  function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] p);
    return (p == TW'(SLOTS - 1)) ? '0 : TW'(p + 1'b1);
  endfunction

  assign alloc_tag     = tail_q;
  assign full_o        = (cnt_q == NW'(SLOTS));
  assign empty_o       = (cnt_q == '0);
  // R4: only the oldest slot may retire
  assign retire_o      = busy_q[head_q] && done_q[head_q];
  assign retire_keep_o = !canc_q[head_q];
  assign retire_len    = len_q[head_q];
  assign retire_data   = data_q[head_q];
  assign pend_bytes    = pend_q;

  always_ff @(posedge clk) begin
    if (rsp_valid && busy_q[rsp_tag] && !done_q[rsp_tag]) data_q[rsp_tag] <= rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      done_q <= '0;
      canc_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
      for (int i = 0; i < SLOTS; i++) len_q[i] <= '0;
    end else begin
      if (cancel_all) canc_q <= canc_q | busy_q;
      if (rsp_valid && busy_q[rsp_tag]) done_q[rsp_tag] <= 1'b1;
      if (retire_o) begin
        busy_q[head_q] <= 1'b0;
        done_q[head_q] <= 1'b0;
        canc_q[head_q] <= 1'b0;
        head_q         <= wrap_inc(head_q);
      end
      if (alloc_en && !full_o) begin
        busy_q[tail_q] <= 1'b1;
        done_q[tail_q] <= 1'b0;
        canc_q[tail_q] <= 1'b0;
        len_q[tail_q]  <= alloc_len;
        tail_q         <= wrap_inc(tail_q);
      end
      cnt_q  <= NW'(cnt_q + ((alloc_en && !full_o) ? NW'(1) : NW'(0)) - (retire_o ? NW'(1) : NW'(0)));
      pend_q <= PBW'(pend_q + ((alloc_en && !full_o) ? PBW'(alloc_len) : PBW'(0))
                            - (retire_o ? PBW'(len_q[head_q]) : PBW'(0)));
    end
  end

  // R2
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) == 32'($countones(busy_q)));
  // R4
  rsp_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (busy_q[rsp_tag] && !done_q[rsp_tag]));
endmodule

// File: rtl/dpf_req_gen.sv
module dpf_req_gen
  import dpf_pkg::*;
#(
  parameter int unsigned ADDR_W     = DPF_ADDR_W,
  parameter int unsigned LEN_W      = DPF_LEN_W,
  parameter int unsigned MAX_REQ    = DPF_MAX_REQ,
  parameter int unsigned FIFO_BYTES = DPF_FIFO_BYTES,
  parameter int unsigned SLOTS      = DPF_SLOTS,
  localparam int unsigned RLW = $clog2(MAX_REQ + 1),
  localparam int unsigned CW  = $clog2(FIFO_BYTES + 1),
  localparam int unsigned PBW = $clog2(SLOTS * MAX_REQ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic              stop_i,
  input  logic              drain_i,
  input  logic              slot_full_i,
  input  logic [CW-1:0]     level_i,
  input  logic [PBW-1:0]    pend_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [RLW-1:0]    req_len_o,
  output logic              issue_o,
  output logic              at_end_o,
  output logic              eob_o
);
  logic [ADDR_W-1:0] next_q, end_q, remain;
  logic [RLW-1:0]    cand_len;
  logic              at_end, at_end_q, room;

  assign at_end = (next_q == end_q);
  assign remain = ADDR_W'(end_q - next_q);

  // R1: smaller of the cap and what is left
  always_comb begin
    if (remain < ADDR_W'(MAX_REQ)) cand_len = RLW'(remain);
    else                           cand_len = RLW'(MAX_REQ);
  end

  // R3: room for everything in flight plus this request
  assign room = (32'(level_i) + 32'(pend_i) + 32'(cand_len)) <= FIFO_BYTES;

  // R2 R5 R10
  assign req_valid_o = !at_end && !slot_full_i && room && !stop_i && !drain_i;
  assign issue_o     = req_valid_o && req_ready_i;
  assign req_addr_o  = next_q;
  assign req_len_o   = cand_len;
  assign at_end_o    = at_end;
  // R8
  assign eob_o       = at_end && !at_end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q   <= '0;
      end_q    <= '0;
      at_end_q <= 1'b1;
    end else begin
      at_end_q <= at_end;
      if (stop_i) begin
        next_q <= end_q;
      end else if (issue_o) begin
        next_q <= ADDR_W'(next_q + ADDR_W'(cand_len));
      end else if (start_i && at_end) begin
        // R7: only accepted once the previous region is fully requested
        next_q <= start_addr_i;
        end_q  <= ADDR_W'(start_addr_i + ADDR_W'(start_len_i));
      end
    end
  end

  // R5
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !req_valid_o);
  // R8
  eob_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eob_o |=> !eob_o);
endmodule

// File: rtl/dma_prefetch_fifo.sv
module dma_prefetch_fifo
  import dpf_pkg::*;
#(
  parameter int unsigned ADDR_W     = DPF_ADDR_W,
  parameter int unsigned LEN_W      = DPF_LEN_W,
  parameter int unsigned FIFO_BYTES = DPF_FIFO_BYTES,
  parameter int unsigned MAX_REQ    = DPF_MAX_REQ,
  parameter int unsigned SLOTS      = DPF_SLOTS,
  parameter int unsigned PULL_BYTES = DPF_PULL_BYTES,
  localparam int unsigned RLW = $clog2(MAX_REQ + 1),
  localparam int unsigned TW  = dpf_bits(SLOTS),
  localparam int unsigned PLW = $clog2(PULL_BYTES + 1),
  localparam int unsigned CW  = $clog2(FIFO_BYTES + 1),
  localparam int unsigned PBW = $clog2(SLOTS * MAX_REQ + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_start_i,
  input  logic [ADDR_W-1:0]       fill_addr_i,
  input  logic [LEN_W-1:0]        fill_len_i,
  input  logic                    fill_stop_i,
  input  logic                    drain_i,
  output logic                    req_valid_o,
  input  logic                    req_ready_i,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [RLW-1:0]          req_len_o,
  output logic [TW-1:0]           req_tag_o,
  input  logic                    rsp_valid_i,
  input  logic [TW-1:0]           rsp_tag_i,
  input  logic [MAX_REQ*8-1:0]    rsp_data_i,
  input  logic                    pull_valid_i,
  input  logic [PLW-1:0]          pull_len_i,
  output logic                    pull_ok_o,
  output logic [PULL_BYTES*8-1:0] pull_data_o,
  output logic                    block_issued_o,
  output logic                    eob_o,
  output logic                    idle_o,
  output logic                    drained_o
);
  logic [CW-1:0]        level;
  logic [PBW-1:0]       pend_bytes;
  logic                 slot_full, slot_empty, issue;
  logic                 retire, retire_keep, fifo_wr;
  logic [RLW-1:0]       retire_len;
  logic [MAX_REQ*8-1:0] retire_data;
  logic                 empty_q;

  dpf_req_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_REQ(MAX_REQ),
    .FIFO_BYTES(FIFO_BYTES), .SLOTS(SLOTS)
  ) u_req_gen (
    .clk(clk), .rst_n(rst_n),
    .start_i(fill_start_i), .start_addr_i(fill_addr_i), .start_len_i(fill_len_i),
    .stop_i(fill_stop_i), .drain_i(drain_i),
    .slot_full_i(slot_full), .level_i(level), .pend_i(pend_bytes),
    .req_ready_i(req_ready_i), .req_valid_o(req_valid_o),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o),
    .issue_o(issue), .at_end_o(block_issued_o), .eob_o(eob_o)
  );

  dpf_slot_pool #(.SLOTS(SLOTS), .MAX_REQ(MAX_REQ)) u_slot_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(issue), .alloc_len(req_len_o), .alloc_tag(req_tag_o),
    .full_o(slot_full), .empty_o(slot_empty),
    .cancel_all(fill_stop_i),
    .rsp_valid(rsp_valid_i), .rsp_tag(rsp_tag_i), .rsp_data(rsp_data_i),
    .retire_o(retire), .retire_keep_o(retire_keep),
    .retire_len(retire_len), .retire_data(retire_data),
    .pend_bytes(pend_bytes)
  );

  // R5: a retirement coinciding with stop is treated as canceled too
  assign fifo_wr = retire && retire_keep && !fill_stop_i;

  // R6
  assign pull_ok_o = pull_valid_i && (pull_len_i != '0) &&
                     (pull_len_i <= PLW'(PULL_BYTES)) &&
                     (32'(level) >= 32'(pull_len_i));

  dpf_byte_fifo #(.DEPTH(FIFO_BYTES), .WR_BYTES(MAX_REQ), .RD_BYTES(PULL_BYTES)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fifo_wr), .wr_len(retire_len), .wr_data(retire_data),
    .rd_en(pull_ok_o), .rd_len(pull_len_i), .rd_data(pull_data_o),
    .level(level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= slot_empty;
  end

  // R9
  assign idle_o    = slot_empty && !empty_q;
  // R10
  assign drained_o = slot_empty;

  // R3
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(level) + 32'(pend_bytes)) <= FIFO_BYTES);
  // R10
  drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained_o |-> (pend_bytes == '0));
endmodule

// File: tb/dma_prefetch_fifo_bench.sv
module dma_prefetch_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0100, 32'h2003, 32'h3001, 32'h4000, 32'h50F0, 32'h6000};
  localparam logic [15:0] V_LEN  [NV] = '{16'd40, 16'd16, 16'd1, 16'd100, 16'd17, 16'd64};

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_start_i = 0, fill_stop_i = 0, drain_i = 0;
  logic [31:0] fill_addr_i = '0;
  logic [15:0] fill_len_i = '0;
  logic req_valid_o, req_ready_i = 1'b1;
  logic [31:0] req_addr_o;
  logic [4:0] req_len_o;
  logic [1:0] req_tag_o;
  logic rsp_valid_i = 0;
  logic [1:0] rsp_tag_i = '0;
  logic [127:0] rsp_data_i = '0;
  logic pull_valid_i = 0;
  logic [2:0] pull_len_i = '0;
  logic pull_ok_o;
  logic [31:0] pull_data_o;
  logic block_issued_o, eob_o, idle_o, drained_o;

  dma_prefetch_fifo u_dma_prefetch_fifo (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int eob_cnt = 0, idle_cnt = 0, req_cnt = 0;
  logic [31:0] mon_exp = '0, mon_end = '0;
  logic [1:0]  q_tag [8];
  logic [31:0] q_addr [8];
  logic [4:0]  q_len [8];
  int q_n = 0;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: records accepted requests and checks their address/length (R1)
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (eob_o) eob_cnt++;
      if (idle_o) idle_cnt++;
      if (req_valid_o && req_ready_i) begin
        logic [31:0] rem;
        logic [4:0]  el;
        rem = mon_end - mon_exp;
        el  = (rem < 32'd16) ? rem[4:0] : 5'd16;
        chk(req_addr_o == mon_exp && req_len_o == el, "R1 request addr/len",
            {27'd0, req_len_o, req_addr_o}, {27'd0, el, mon_exp});
        q_tag[q_n] = req_tag_o; q_addr[q_n] = req_addr_o; q_len[q_n] = req_len_o;
        q_n++;
        mon_exp = mon_exp + 32'(req_len_o);
        req_cnt++;
      end
    end
  end

  task automatic drive_rsp(input int k);
    rsp_valid_i = 1'b1;
    rsp_tag_i   = q_tag[k];
    for (int b = 0; b < 16; b++)
      rsp_data_i[b*8 +: 8] = (b < 32'(q_len[k])) ? mb(q_addr[k] + 32'(b)) : 8'h00;
  endtask

  task automatic pop(input int k);
    for (int j = k; j < q_n - 1; j++) begin
      q_tag[j] = q_tag[j+1]; q_addr[j] = q_addr[j+1]; q_len[j] = q_len[j+1];
    end
    q_n--;
  endtask

  task automatic end_cycle();
    @(posedge clk);
    #1;
    fill_start_i = 0; fill_stop_i = 0; rsp_valid_i = 0; pull_valid_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); end_cycle(); end
  endtask

  task automatic respond(input int k);
    @(negedge clk);
    drive_rsp(k);
    end_cycle();
    pop(k);
  endtask

  task automatic start_fill(input logic [31:0] a, input logic [15:0] l, input bit track);
    @(negedge clk);
    fill_start_i = 1; fill_addr_i = a; fill_len_i = l;
    if (track) begin mon_exp = a; mon_end = a + 32'(l); end
    end_cycle();
  endtask

  task automatic do_pull(input int n, input bit exp_ok, input logic [31:0] a, input string rq);
    @(negedge clk);
    pull_valid_i = 1; pull_len_i = 3'(n);
    #1;
    chk(pull_ok_o == exp_ok, rq, 64'(pull_ok_o), 64'(exp_ok));
    if (pull_ok_o && exp_ok)
      for (int i = 0; i < n; i++)
        chk(pull_data_o[i*8 +: 8] == mb(a + 32'(i)), rq, 64'(pull_data_o[i*8 +: 8]), 64'(mb(a + 32'(i))));
    end_cycle();
  endtask

  task automatic run_block(input logic [31:0] a, input logic [15:0] l);
    int consumed, e0, guard;
    logic [31:0] rd;
    e0 = eob_cnt; consumed = 0; rd = a; guard = 0;
    start_fill(a, l, 1'b1);
    while (!(consumed == 32'(l) && q_n == 0 && mon_exp == mon_end) && guard < 3000) begin
      bit sent;
      int n;
      guard++;
      @(negedge clk);
      sent = (q_n > 0);
      if (sent) drive_rsp(0);
      n = 32'(l) - consumed;
      if (n > 4) n = 4;
      if (n > 0) begin pull_valid_i = 1; pull_len_i = 3'(n); end
      #1;
      if (n > 0 && pull_ok_o) begin
        for (int i = 0; i < n; i++)
          chk(pull_data_o[i*8 +: 8] == mb(rd + 32'(i)), "R4 R6 stream byte order",
              64'(pull_data_o[i*8 +: 8]), 64'(mb(rd + 32'(i))));
        consumed += n; rd += 32'(n);
      end
      end_cycle();
      if (sent) pop(0);
    end
    idle(2);
    chk(consumed == 32'(l), "R4 block fully delivered", 64'(consumed), 64'(l));
    chk(eob_cnt - e0 == 1, "R8 one eob pulse per block", 64'(eob_cnt - e0), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(req_valid_o == 0, "R11 no request after reset", 64'(req_valid_o), 0);
    chk(drained_o == 1 && block_issued_o == 1, "R11 drained/issued after reset",
        {62'd0, drained_o, block_issued_o}, 64'd3);
    do_pull(1, 1'b0, 32'h0, "R11 pull fails when empty");

    // table walk
    for (int v = 0; v < NV; v++) run_block(V_ADDR[v], V_LEN[v]);

    // R2 slot limit, R4 in-order retirement, R3 admission, R5 stop, R9 idle
    r0 = req_cnt;
    start_fill(32'h8000, 16'd128, 1'b1);
    idle(6);
    chk(req_cnt - r0 == 3, "R2 slot limit caps outstanding", 64'(req_cnt - r0), 64'd3);
    chk(req_valid_o == 0, "R2 no offer with all slots busy", 64'(req_valid_o), 0);
    respond(2);
    idle(3);
    do_pull(1, 1'b0, 32'h0, "R4 later completion waits for head");
    respond(0);
    respond(0);
    idle(5);
    chk(req_cnt - r0 == 4, "R3 capacity admits only one more", 64'(req_cnt - r0), 64'd4);
    chk(req_valid_o == 0, "R3 held off with free slot", 64'(req_valid_o), 0);
    for (int i = 0; i < 4; i++) do_pull(4, 1'b1, 32'h8000 + 32'(4*i), "R4 issue-order data");
    idle(3);
    chk(req_cnt - r0 == 5, "R3 room reopens after pull", 64'(req_cnt - r0), 64'd5);
    i0 = idle_cnt;
    @(negedge clk); fill_stop_i = 1; end_cycle();
    idle(2);
    chk(req_valid_o == 0 && block_issued_o == 1, "R5 stop ends region",
        {62'd0, req_valid_o, block_issued_o}, 64'd1);
    chk(drained_o == 0, "R10 not drained with reads out", 64'(drained_o), 0);
    respond(0);
    respond(0);
    idle(4);
    chk(idle_cnt - i0 == 1, "R9 idle pulse on last retire", 64'(idle_cnt - i0), 64'd1);
    chk(drained_o == 1, "R10 drained once all retired", 64'(drained_o), 1);
    for (int i = 0; i < 8; i++) do_pull(4, 1'b1, 32'h8010 + 32'(4*i), "R5 earlier data kept");
    do_pull(1, 1'b0, 32'h0, "R5 canceled data discarded");

    // R7 start ignored while region active
    req_ready_i = 0;
    start_fill(32'h9000, 16'd32, 1'b1);
    idle(2);
    start_fill(32'hA000, 16'd8, 1'b0);
    idle(2);
    chk(req_valid_o == 1 && req_addr_o == 32'h9000, "R7 busy start ignored",
        64'(req_addr_o), 64'h9000);
    req_ready_i = 1;
    idle(4);
    respond(0);
    respond(0);
    idle(4);
    for (int i = 0; i < 8; i++) do_pull(4, 1'b1, 32'h9000 + 32'(4*i), "R7 original region data");
    chk(block_issued_o == 1, "R7 region completes", 64'(block_issued_o), 1);

    // R10 drain holds off requests
    drain_i = 1;
    r0 = req_cnt;
    start_fill(32'hB000, 16'd16, 1'b1);
    idle(3);
    chk(req_cnt == r0 && drained_o == 1, "R10 drain blocks offer", 64'(req_cnt - r0), 0);
    drain_i = 0;
    idle(2);
    chk(req_cnt - r0 == 1 && drained_o == 0, "R10 request after drain", 64'(req_cnt - r0), 1);
    respond(0);
    idle(3);
    chk(drained_o == 1, "R10 drained after response", 64'(drained_o), 1);
    for (int i = 0; i < 4; i++) do_pull(4, 1'b1, 32'hB000 + 32'(4*i), "R10 drained data");

    // R8 zero-length start
    i0 = eob_cnt;
    start_fill(32'hD000, 16'd0, 1'b1);
    idle(3);
    chk(eob_cnt == i0 && req_valid_o == 0, "R8 no pulse for empty region", 64'(eob_cnt - i0), 0);

    // R6 pull boundaries
    start_fill(32'hC000, 16'd6, 1'b1);
    idle(3);
    respond(0);
    idle(3);
    do_pull(4, 1'b1, 32'hC000, "R6 pull within level");
    do_pull(4, 1'b0, 32'h0, "R6 short level refuses");
    do_pull(2, 1'b1, 32'hC004, "R6 exact level, nothing lost");
    do_pull(1, 1'b0, 32'h0, "R6 empty after exact pull");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule